// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns a stream of bus write cycles into command strobes for an on-chip flash controller. Each write arrives as a single-cycle strobe with its address and data already latched. The decoder looks for a two-write unlock prefix at fixed key addresses, then a command byte. From that it issues one-cycle strobes for program (with the target address and data), chip erase, sector erase (with the sector index), reset-to-read, erase suspend and erase resume. It also keeps a read-mode select that switches array reads over to an identifier/protection readout.

The host can address the part in byte units or in word units, and the key addresses follow that choice. The erase scheduler reports its phase on a small status input: idle, collection window, running or suspended. The decoder uses that phase to decide which single-write commands are legal. The program engine raises a busy flag, and every write is dropped while it is high. A low-supply inhibit input clears all decoder state and blocks writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: In word mode, the sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then a data write to any address makes `prog_go` high for exactly one cycle. It rises in the cycle after the fourth write, and `prog_addr`/`prog_data` then hold that write's full address and data.
- R2: When `byte_mode`=1, the key addresses are compared on byte address bits [15:0] and are AAAAh (first/command) and 5555h (second). In word mode they are compared on bits [14:0] and are 5555h and 2AAAh.
- R3: Address bits above the compared key field (word A17–A15) and data bits above bit 7 are ignored during unlock and command writes.
- R4: The sequence AAh@key1, 55h@key2, 80h@key1, AAh@key1, 55h@key2, 10h@key1 gives one `chip_erase_go` pulse.
- R5: The same six-write prefix ending in 30h at any address gives one `sect_erase_go` pulse. `sect_idx` equals the top SECT_BITS of the word address of that last write (word address = byte address >> 1 in byte mode).
- R6: A wrong address or data value at any step of a sequence drops the partial sequence without any strobe. A correct sequence started on the very next write is accepted.
- R7: A write of F0h at any address, outside a program data cycle, gives one `read_reset_go` pulse and clears autoselect. Autoselect, entered by 90h as the command byte, stays set through other writes.
- R8: In autoselect, `id_data` is combinational on `rd_addr`. Word offset 00h gives the manufacturer code, 01h gives the device code (low byte only in byte mode), and 02h gives 1 if `sect_protect[sector of rd_addr]` is set, else 0. Other offsets, and any read outside autoselect, give 0.
- R9: While `prog_busy`=1, writes produce no strobe and do not advance the sequence.
- R10: In the erase window phase (`ers_state`=1), a single write of 30h adds a sector (`sect_erase_go` with its index), B0h gives `suspend_go`, and any other value gives `read_reset_go`.
- R11: In the running phase (`ers_state`=2), only B0h is accepted (`suspend_go`). In the suspended phase (3), only 30h is accepted (`resume_go`). All other writes have no effect.
- R12: While `lv_inhibit`=1, writes give no strobe and autoselect is cleared from the next cycle. No partial sequence survives the inhibit.
- R13: After reset all strobes and `autosel_mode` are low, and no more than one strobe is ever high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lv_inhibit | input | 1 | Low-supply inhibit: blocks writes, forces read mode |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_addr | input | WORD_AW+1 | Write address (byte units in byte mode, word units otherwise) |
| wr_data | input | DATA_W | Write data |
| prog_busy | input | 1 | Program engine (or chip erase) running |
| ers_state | input | 2 | Erase scheduler phase: 0 idle, 1 window, 2 running, 3 suspended |
| rd_addr | input | WORD_AW+1 | Read address for the identifier readout |
| sect_protect | input | 2**SECT_BITS | Per-sector protection flags |
| prog_go | output | 1 | Program start strobe |
| prog_addr | output | WORD_AW+1 | Program target address |
| prog_data | output | DATA_W | Program data |
| chip_erase_go | output | 1 | Chip erase strobe |
| sect_erase_go | output | 1 | Sector erase (add sector) strobe |
| sect_idx | output | SECT_BITS | Sector index for the sector strobe |
| suspend_go | output | 1 | Erase suspend strobe |
| resume_go | output | 1 | Erase resume strobe |
| read_reset_go | output | 1 | Reset-to-read strobe |
| autosel_mode | output | 1 | Read mode select: 1 = identifier readout |
| id_data | output | DATA_W | Identifier / protection read data |

## Verification
The hardest case is an abort at a given depth inside the six-write erase prefix, because each depth needs its own exact preamble. The bench sweeps every step in both addressing modes. At each step it corrupts either the data or the address, then proves the decoder went back to idle by running a full program sequence straight afterwards. The busy and inhibit cases are checked the same way: a lone data write sent after the blocking input drops must not give a program strobe.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [7:0] CMD_UNLK_A = 8'hAA;
   localparam logic [7:0] CMD_UNLK_B = 8'h55;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_ESETUP = 8'h80;
   localparam logic [7:0] CMD_RESET  = 8'hF0;
   localparam logic [7:0] CMD_CHIP   = 8'h10;
   localparam logic [7:0] CMD_SECT   = 8'h30;
   localparam logic [7:0] CMD_SUSP   = 8'hB0;
   localparam logic [7:0] CMD_RESUME = 8'h30;

   localparam logic [14:0] WKEY_FIRST  = 15'h5555;
   localparam logic [14:0] WKEY_SECOND = 15'h2AAA;
   localparam logic [15:0] BKEY_FIRST  = 16'hAAAA;
   localparam logic [15:0] BKEY_SECOND = 16'h5555;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_UNLK1, SQ_UNLK2, SQ_PDATA, SQ_ERS0, SQ_ERS1, SQ_ERS2
   } seq_e;

   typedef enum logic [1:0] {
      EPH_IDLE = 2'd0, EPH_WINDOW = 2'd1, EPH_RUN = 2'd2, EPH_SUSP = 2'd3
   } ers_phase_e;

   typedef struct packed {
      logic prog;
      logic chip;
      logic sect;
      logic susp;
      logic resm;
      logic rst;
   } strobe_t;

   function automatic logic key_hit(input logic [15:0] a, input logic bm,
                                    input logic first);
      if (bm) return a == (first ? BKEY_FIRST : BKEY_SECOND);
      else    return a[14:0] == (first ? WKEY_FIRST : WKEY_SECOND);
   endfunction

   function automatic logic odd_par8(input logic [7:0] v);
      return ^v;
   endfunction

endpackage

// File: rtl/fcd_addr_map.sv
module fcd_addr_map #(
   parameter int WORD_AW   = 18,
   parameter int SECT_BITS = 3,
   localparam int ADDR_W   = WORD_AW + 1
) (
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic                 byte_mode,
   output logic                 key1_hit,
   output logic                 key2_hit,
   output logic [SECT_BITS-1:0] wr_sect,
   output logic [SECT_BITS-1:0] rd_sect,
   output logic [7:0]           rd_off
);
   import flash_cmd_pkg::*;

   logic [ADDR_W-1:0]    src  [2];
   logic [WORD_AW-1:0]   word [2];
   logic [SECT_BITS-1:0] sect [2];

   assign src[0] = wr_addr;
   assign src[1] = rd_addr;

   for (genvar p = 0; p < 2; p++) begin : g_port
      assign word[p] = byte_mode ? src[p][ADDR_W-1:1] : src[p][WORD_AW-1:0];
      assign sect[p] = word[p][WORD_AW-1 -: SECT_BITS];
   end

   assign wr_sect  = sect[0];
   assign rd_sect  = sect[1];
   assign rd_off   = word[1][7:0];
   assign key1_hit = key_hit(wr_addr[15:0], byte_mode, 1'b1);
   assign key2_hit = key_hit(wr_addr[15:0], byte_mode, 1'b0);

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lv_inhibit,
   input  logic                    wr_valid,
   input  logic [7:0]              cmd,
   input  logic                    key1,
   input  logic                    key2,
   input  logic                    prog_busy,
   input  logic [1:0]              ers_state,
   output flash_cmd_pkg::strobe_t  ev_next,
   output flash_cmd_pkg::strobe_t  ev_q,
   output logic                    auto_q
);
   import flash_cmd_pkg::*;

   seq_e       seq_q, seq_d;
   logic       auto_d;
   strobe_t    ev_d;
   ers_phase_e eph;

   assign eph     = ers_phase_e'(ers_state);
   assign ev_next = ev_d;

   always_comb begin
      seq_d  = seq_q;
      auto_d = auto_q;
      ev_d   = '0;
      if (lv_inhibit) begin
         seq_d  = SQ_IDLE;
         auto_d = 1'b0;
      end else if (wr_valid && !prog_busy) begin
         unique case (eph)
            EPH_WINDOW: begin
               seq_d = SQ_IDLE;
               if (cmd == CMD_SECT)      ev_d.sect = 1'b1;
               else if (cmd == CMD_SUSP) ev_d.susp = 1'b1;
               else                      ev_d.rst  = 1'b1;
            end
            EPH_RUN: begin
               if (cmd == CMD_SUSP) ev_d.susp = 1'b1;
            end
            EPH_SUSP: begin
               if (cmd == CMD_RESUME) ev_d.resm = 1'b1;
            end
            default: begin
               if (seq_q == SQ_PDATA) begin
                  ev_d.prog = 1'b1;
                  seq_d     = SQ_IDLE;
                  auto_d    = 1'b0;
               end else if (cmd == CMD_RESET) begin
                  ev_d.rst = 1'b1;
                  seq_d    = SQ_IDLE;
                  auto_d   = 1'b0;
               end else begin
                  seq_d = SQ_IDLE;
                  unique case (seq_q)
                     SQ_IDLE:  if (key1 && cmd == CMD_UNLK_A) seq_d = SQ_UNLK1;
                     SQ_UNLK1: if (key2 && cmd == CMD_UNLK_B) seq_d = SQ_UNLK2;
                     SQ_UNLK2: begin
                        if (key1 && cmd == CMD_PROG)   seq_d = SQ_PDATA;
                        if (key1 && cmd == CMD_ESETUP) seq_d = SQ_ERS0;
                        if (key1 && cmd == CMD_IDENT)  auto_d = 1'b1;
                     end
                     SQ_ERS0:  if (key1 && cmd == CMD_UNLK_A) seq_d = SQ_ERS1;
                     SQ_ERS1:  if (key2 && cmd == CMD_UNLK_B) seq_d = SQ_ERS2;
                     SQ_ERS2: begin
                        if (key1 && cmd == CMD_CHIP) begin
                           ev_d.chip = 1'b1;
                           auto_d    = 1'b0;
                        end else if (cmd == CMD_SECT) begin
                           ev_d.sect = 1'b1;
                           auto_d    = 1'b0;
                        end
                     end
                     default: seq_d = SQ_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= SQ_IDLE;
         auto_q <= 1'b0;
         ev_q   <= '0;
      end else begin
         seq_q  <= seq_d;
         auto_q <= auto_d;
         ev_q   <= ev_d;
      end
   end

endmodule

// File: rtl/fcd_idread.sv
module fcd_idread #(
   parameter int          DATA_W    = 16,
   parameter int          SECT_BITS = 3,
   parameter logic [7:0]  MFR_CODE  = 8'h01,
   parameter logic [15:0] DEV_CODE  = 16'h22D9,
   localparam int         NUM_SECT  = 1 << SECT_BITS
) (
   input  logic                 auto_on,
   input  logic                 byte_mode,
   input  logic [7:0]           off,
   input  logic [SECT_BITS-1:0] sect,
   input  logic [NUM_SECT-1:0]  prot,
   output logic [DATA_W-1:0]    id_data
);
   logic [DATA_W-1:0] dev_val;

   if (DATA_W > 8) begin : g_wide
      assign dev_val = byte_mode ? DATA_W'(DEV_CODE[7:0]) : DATA_W'(DEV_CODE);
   end else begin : g_narrow
      logic unused_bm;
      assign unused_bm = byte_mode;
      assign dev_val   = DEV_CODE[7:0];
   end

   always_comb begin
      id_data = '0;
      if (auto_on) begin
         unique case (off)
            8'h00:   id_data = DATA_W'(MFR_CODE);
            8'h01:   id_data = dev_val;
            8'h02:   id_data = DATA_W'(prot[sect]);
            default: id_data = '0;
         endcase
      end
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int          WORD_AW   = 18,
   parameter int          DATA_W    = 16,
   parameter int          SECT_BITS = 3,
   parameter logic [7:0]  MFR_CODE  = 8'h01,
   parameter logic [15:0] DEV_CODE  = 16'h22D9,
   localparam int         ADDR_W    = WORD_AW + 1,
   localparam int         NUM_SECT  = 1 << SECT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lv_inhibit,
   input  logic                 byte_mode,
   input  logic                 wr_valid,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 prog_busy,
   input  logic [1:0]           ers_state,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic [NUM_SECT-1:0]  sect_protect,
   output logic                 prog_go,
   output logic [ADDR_W-1:0]    prog_addr,
   output logic [DATA_W-1:0]    prog_data,
   output logic                 chip_erase_go,
   output logic                 sect_erase_go,
   output logic [SECT_BITS-1:0] sect_idx,
   output logic                 suspend_go,
   output logic                 resume_go,
   output logic                 read_reset_go,
   output logic                 autosel_mode,
   output logic [DATA_W-1:0]    id_data
);
   import flash_cmd_pkg::*;

   if (WORD_AW < 16) begin : g_bad_aw
      $error("WORD_AW must cover the 15-bit key field plus one");
   end
   if (SECT_BITS < 1 || SECT_BITS > WORD_AW - 15) begin : g_bad_sb
      $error("SECT_BITS must sit above the key field");
   end
   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_dw
      $error("DATA_W must be 8 or 16");
   end
   if (!odd_par8(MFR_CODE) || !odd_par8(DEV_CODE[7:0])) begin : g_bad_par
      $error("identifier codes need odd parity");
   end

   logic                 key1, key2;
   logic [SECT_BITS-1:0] wsect, rsect;
   logic [7:0]           roff;
   strobe_t              ev_next, ev_q;

   fcd_addr_map #(.WORD_AW(WORD_AW), .SECT_BITS(SECT_BITS)) u_map (
      .wr_addr  (wr_addr),
      .rd_addr  (rd_addr),
      .byte_mode(byte_mode),
      .key1_hit (key1),
      .key2_hit (key2),
      .wr_sect  (wsect),
      .rd_sect  (rsect),
      .rd_off   (roff)
   );

   fcd_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .lv_inhibit(lv_inhibit),
      .wr_valid  (wr_valid),
      .cmd       (wr_data[7:0]),
      .key1      (key1),
      .key2      (key2),
      .prog_busy (prog_busy),
      .ers_state (ers_state),
      .ev_next   (ev_next),
      .ev_q      (ev_q),
      .auto_q    (autosel_mode)
   );

   fcd_idread #(.DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
                .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
      .auto_on  (autosel_mode),
      .byte_mode(byte_mode),
      .off      (roff),
      .sect     (rsect),
      .prot     (sect_protect),
      .id_data  (id_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_addr <= '0;
         prog_data <= '0;
         sect_idx  <= '0;
      end else begin
         if (ev_next.prog) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
         if (ev_next.sect) sect_idx <= wsect;
      end
   end

   assign prog_go       = ev_q.prog;
   assign chip_erase_go = ev_q.chip;
   assign sect_erase_go = ev_q.sect;
   assign suspend_go    = ev_q.susp;
   assign resume_go     = ev_q.resm;
   assign read_reset_go = ev_q.rst;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lv_inhibit,
   input logic              wr_valid,
   input logic              prog_busy,
   input logic [1:0]        ers_state,
   input logic              prog_go,
   input logic              chip_erase_go,
   input logic              sect_erase_go,
   input logic              suspend_go,
   input logic              resume_go,
   input logic              read_reset_go,
   input logic              autosel_mode,
   input logic [DATA_W-1:0] id_data
);
   logic [5:0] stb;
   assign stb = {prog_go, chip_erase_go, sect_erase_go,
                 suspend_go, resume_go, read_reset_go};

   // R1
   prog_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> $past(wr_valid));

   // R13
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb));

   // R9
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && prog_busy) |=> (stb == 6'b0));

   // R12
   inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lv_inhibit |=> (!autosel_mode && stb == 6'b0));

   // R11
   resume_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_go |-> ($past(ers_state) == 2'd3));

   // R5
   sect_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sect_erase_go |-> ($past(ers_state) <= 2'd1));

   // R8
   id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !autosel_mode |-> (id_data == '0));

endmodule

bind flash_cmd_decoder fcd_checker #(.DATA_W(DATA_W)) u_fcd_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lv_inhibit   (lv_inhibit),
   .wr_valid     (wr_valid),
   .prog_busy    (prog_busy),
   .ers_state    (ers_state),
   .prog_go      (prog_go),
   .chip_erase_go(chip_erase_go),
   .sect_erase_go(sect_erase_go),
   .suspend_go   (suspend_go),
   .resume_go    (resume_go),
   .read_reset_go(read_reset_go),
   .autosel_mode (autosel_mode),
   .id_data      (id_data)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
   localparam int          WORD_AW = 18;
   localparam int          DATA_W  = 16;
   localparam int          SB      = 3;
   localparam int          AW      = WORD_AW + 1;
   localparam int          NS      = 1 << SB;
   localparam logic [15:0] DEV     = 16'h22D9;
   localparam logic [7:0]  MFR     = 8'h01;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lv_inhibit = 1'b0, byte_mode = 1'b0, wr_valid = 1'b0, prog_busy = 1'b0;
   logic [AW-1:0]     wr_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [1:0]        ers_state = 2'd0;
   logic [NS-1:0]     sect_protect = 8'b1010_0110;
   logic prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go, read_reset_go, autosel_mode;
   logic [AW-1:0]     prog_addr;
   logic [DATA_W-1:0] prog_data, id_data;
   logic [SB-1:0]     sect_idx;

   int n_chk = 0, n_bad = 0;
   logic [5:0] sv;
   bit done = 0;

   always #5 clk = ~clk;

   flash_cmd_decoder #(.WORD_AW(WORD_AW), .DATA_W(DATA_W), .SECT_BITS(SB),
                       .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (.*);

   localparam logic [5:0] S_PROG = 6'b100000, S_CHIP = 6'b010000, S_SECT = 6'b001000,
                          S_SUSP = 6'b000100, S_RESM = 6'b000010, S_RST = 6'b000001,
                          S_NONE = 6'b000000;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic logic [AW-1:0] k1();
      return byte_mode ? AW'(16'hAAAA) : AW'(15'h5555);
   endfunction
   function automatic logic [AW-1:0] k2();
      return byte_mode ? AW'(16'h5555) : AW'(15'h2AAA);
   endfunction
   function automatic logic [AW-1:0] wa(input logic [WORD_AW-1:0] w);
      return byte_mode ? {w, 1'b0} : AW'(w);
   endfunction

   task automatic wr(input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      sv = {prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go, read_reset_go};
   endtask

   task automatic prog_seq(input logic [WORD_AW-1:0] w, input logic [DATA_W-1:0] d,
                           input string req);
      wr(k1(), 16'h00AA); chk(req, sv, S_NONE);
      wr(k2(), 16'h0055); chk(req, sv, S_NONE);
      wr(k1(), 16'h00A0); chk(req, sv, S_NONE);
      wr(wa(w), d);
      chk(req, sv, S_PROG);
      chk(req, prog_addr, wa(w));
      chk(req, prog_data, d);
   endtask

   task automatic erase_pre();
      wr(k1(), 16'h00AA); wr(k2(), 16'h0055); wr(k1(), 16'h0080);
      wr(k1(), 16'h00AA); wr(k2(), 16'h0055);
   endtask

   task automatic enter_auto();
      wr(k1(), 16'h00AA); wr(k2(), 16'h0055); wr(k1(), 16'h0090);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13", {prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go, read_reset_go}, S_NONE);
      chk("R13", autosel_mode, 0);

      // R1 / R2 program sweep in both modes
      for (int i = 0; i < 16; i++) begin
         byte_mode = i[0];
         prog_seq(WORD_AW'(i * 16411 + 7), DATA_W'(i * 16'h1357 ^ 16'hA5C3), i[0] ? "R2" : "R1");
      end

      // R3 don't-care upper address bits and upper data byte
      for (int m = 0; m < 2; m++) begin
         byte_mode = m[0];
         wr(k1() | (AW'(3'b101) << (15 + m)), 16'h7EAA);
         wr(k2() | (AW'(3'b011) << (15 + m)), 16'h3355);
         wr(k1() | (AW'(3'b111) << (15 + m)), 16'hC3A0);
         wr(wa(18'h1234), 16'hBEEF);
         chk("R3", sv, S_PROG);
         chk("R3", prog_data, 16'hBEEF);
      end

      // R4 chip erase
      for (int m = 0; m < 2; m++) begin
         byte_mode = m[0];
         erase_pre(); chk("R4", sv, S_NONE);
         wr(k1(), 16'h0010); chk("R4", sv, S_CHIP);
      end

      // R5 sector erase, every sector, both modes
      for (int m = 0; m < 2; m++) begin
         byte_mode = m[0];
         for (int s = 0; s < NS; s++) begin
            erase_pre();
            wr(wa(WORD_AW'(s) << (WORD_AW - SB) | WORD_AW'(s * 3)), 16'h0030);
            chk("R5", sv, S_SECT);
            chk("R5", sect_idx, s);
         end
      end

      // R6 abort at every step by data or by address
      for (int m = 0; m < 2; m++) begin
         byte_mode = m[0];
         for (int step = 0; step < 6; step++) begin
            for (int kind = 0; kind < 2; kind++) begin
               logic [AW-1:0] as [6];
               logic [7:0]    ds [6];
               as[0] = k1(); as[1] = k2(); as[2] = k1(); as[3] = k1(); as[4] = k2(); as[5] = k1();
               ds[0] = 8'hAA; ds[1] = 8'h55; ds[2] = 8'h80; ds[3] = 8'hAA; ds[4] = 8'h55; ds[5] = 8'h10;
               for (int j = 0; j < step; j++) wr(as[j], {8'h00, ds[j]});
               if (kind == 0) wr(as[step], {8'h00, ds[step] ^ 8'h01});
               else           wr(as[step] ^ AW'(1), {8'h00, ds[step]});
               chk("R6", sv, S_NONE);
               prog_seq(WORD_AW'(step * 97 + kind), DATA_W'(step * 16'h0101 + kind), "R6");
            end
         end
      end

      // R7 reset command
      byte_mode = 1'b0;
      wr(k1(), 16'h00AA);
      wr(18'h3_0000, 16'h00F0); chk("R7", sv, S_RST);
      wr(k2(), 16'h0055); wr(k1(), 16'h00A0); chk("R7", sv, S_NONE);
      enter_auto();
      chk("R7", autosel_mode, 1);
      wr(k1(), 16'h00AA); wr(k1(), 16'h0012); wr(18'h0042, 16'h0030);
      chk("R7", autosel_mode, 1);
      wr(18'h1_2345, 16'h00F0);
      chk("R7", sv, S_RST);
      chk("R7", autosel_mode, 0);

      // R8 identifier readout
      for (int m = 0; m < 2; m++) begin
         byte_mode = m[0];
         enter_auto();
         @(negedge clk);
         rd_addr = wa(18'h2_0F00); #1;
         chk("R8", id_data, MFR);
         chk("R8", ^id_data[7:0], 1);
         rd_addr = wa(18'h1_7701); #1;
         chk("R8", id_data, m ? {8'h00, DEV[7:0]} : DEV);
         chk("R8", ^id_data[7:0], 1);
         for (int s = 0; s < NS; s++) begin
            rd_addr = wa(WORD_AW'(s) << (WORD_AW - SB) | 18'h0502); #1;
            chk("R8", id_data, sect_protect[s]);
         end
         rd_addr = wa(18'h0003); #1;
         chk("R8", id_data, 0);
         wr(k1(), 16'h00F0);
         @(negedge clk);
         rd_addr = wa(18'h0001); #1;
         chk("R8", id_data, 0);
      end

      // R9 busy ignores writes
      byte_mode = 1'b0;
      prog_busy = 1'b1;
      wr(k1(), 16'h00AA); chk("R9", sv, S_NONE);
      wr(k2(), 16'h0055); wr(k1(), 16'h00A0);
      wr(18'h0777, 16'h1111); chk("R9", sv, S_NONE);
      wr(k1(), 16'h00F0); chk("R9", sv, S_NONE);
      prog_busy = 1'b0;
      wr(18'h0777, 16'h2222); chk("R9", sv, S_NONE);

      // R10 erase window
      ers_state = 2'd1;
      wr(18'h2_8000, 16'h0030); chk("R10", sv, S_SECT); chk("R10", sect_idx, 5);
      wr(18'h3_C000, 16'h0030); chk("R10", sv, S_SECT); chk("R10", sect_idx, 7);
      wr(18'h0000, 16'h00B0); chk("R10", sv, S_SUSP);
      wr(k1(), 16'h00AA);     chk("R10", sv, S_RST);

      // R11 running and suspended phases
      ers_state = 2'd2;
      wr(18'h0000, 16'h0030); chk("R11", sv, S_NONE);
      wr(18'h0000, 16'h00F0); chk("R11", sv, S_NONE);
      wr(18'h0100, 16'h00B0); chk("R11", sv, S_SUSP);
      ers_state = 2'd3;
      wr(18'h0000, 16'h00B0); chk("R11", sv, S_NONE);
      wr(18'h0000, 16'h00F0); chk("R11", sv, S_NONE);
      wr(18'h0200, 16'h0030); chk("R11", sv, S_RESM);
      ers_state = 2'd0;

      // R12 low-supply inhibit
      enter_auto();
      chk("R12", autosel_mode, 1);
      wr(k1(), 16'h00AA); wr(k2(), 16'h0055); wr(k1(), 16'h00A0);
      lv_inhibit = 1'b1;
      @(negedge clk);
      chk("R12", autosel_mode, 0);
      wr(18'h0333, 16'h4444); chk("R12", sv, S_NONE);
      wr(k1(), 16'h00F0);     chk("R12", sv, S_NONE);
      lv_inhibit = 1'b0;
      wr(18'h0333, 16'h5555); chk("R12", sv, S_NONE);
      prog_seq(18'h0333, 16'h6666, "R12");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule